// File: doc/BRIEF.md
# Flash-to-Memory Read DMA Engine

This engine copies a block of serial-flash contents into system memory. Software loads three address registers: the flash source address, the first destination address and the destination address just past the block. It then writes the start command. The engine checks the programming. If the programming is valid, it asks the flash read sequencer for a byte stream starting at the source address. It collects the bytes into 16-byte beats and hands each beat, with its destination address, to a memory write port.

Both streaming sides use valid/ready handshakes. A byte moves from the flash sequencer when `fl_valid` and `fl_ready` are both high at a rising edge. A beat moves to memory when `mem_valid` and `mem_ready` are both high at a rising edge. While `mem_valid` waits for `mem_ready`, the beat, its address and `mem_valid` stay unchanged. The engine holds one finished beat while the memory side is stalled. If the next beat is complete before that beat leaves, the engine drops `fl_ready` rather than lose a byte.

When the last beat is accepted, the busy flag clears by itself and completion status bit 7 is set. Software clears status bits by writing ones to them. The interrupt line is the OR of the status bits that are also enabled in an 8-bit enable mask.

Top module: `flash_rd_dma`

## Requirements
- R1: After reset, `dma_busy`, `dma_err`, `irq`, `fl_req` and `mem_valid` are 0, and `irq_stat` is 0x00.
- R2: Writing a 1 to bit 0 of the control selection (`cfg_sel`=3) with valid programming sets `dma_busy` on that edge, and `fl_req` is raised with `fl_addr` equal to the source address. `dma_busy` clears by itself on the edge that accepts the last beat. `mem_valid` is never high while `dma_busy` is low.
- R3: A start is rejected and `dma_err` is set, with `dma_busy` staying 0 and no byte or beat moved, if any of the following holds: the source (`cfg_sel`=0), destination start (`cfg_sel`=1) or destination end (`cfg_sel`=2) address has a nonzero value in bits 3:0; the end address is not above the start address; or end minus start exceeds 4 MiB. The next accepted start clears `dma_err`.
- R4: Flash byte number n of a transfer is placed in byte lane n mod 16 of a beat, at bits 8k+7:8k for lane k. That beat carries `mem_addr` equal to the destination start plus 16 × floor(n/16).
- R5: Beats are issued in rising address order. While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values.
- R6: Under any pattern of `mem_ready` and `fl_valid`, no flash byte is lost or duplicated: every beat has exactly the expected content.
- R7: On the edge that accepts the last beat, status bit 7 is set.
- R8: A write to the status selection (`cfg_sel`=4) clears each status bit whose write-data bit is 1, and leaves the bits written with 0 unchanged.
- R9: `irq` is high exactly when some bit is set in both the status and the enable mask (`cfg_sel`=5, 8 bits).
- R10: A start command written while `dma_busy` is high has no effect. The running transfer completes with its original source, destination and length, and signals completion once.
- R11: Exactly end-minus-start flash bytes are accepted per transfer. `fl_ready` stays low once that many have been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 source, 1 dest start, 2 dest end, 3 control, 4 status clear, 5 enable |
| cfg_wdata | input | 32 | Configuration write data |
| dma_busy | output | 1 | Start bit; high while a transfer runs |
| dma_err | output | 1 | Last start was rejected for bad programming |
| irq_stat | output | 8 | Interrupt status, bit 7 = transfer complete |
| irq | output | 1 | Interrupt request |
| fl_req | output | 1 | Byte stream wanted from the flash sequencer |
| fl_addr | output | 32 | Flash address where the stream begins |
| fl_valid | input | 1 | Flash byte valid |
| fl_ready | output | 1 | Engine accepts a flash byte |
| fl_data | input | 8 | Flash byte |
| mem_valid | output | 1 | Beat valid toward memory |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | 32 | Beat destination address |
| mem_data | output | 128 | Beat data, lane 0 in bits 7:0 |

## Verification
The assertions assume three things about the environment. The flash sequencer supplies bytes from `fl_addr` onward in order. No configuration write lands on the same edge as a status set, except the start-while-busy case. The memory side keeps any `mem_ready` pattern, with no further protocol duties. The bench stays within these assumptions by driving every input on the falling edge from one model process. That process derives each flash byte arithmetically from its address, and toggles `fl_valid` and `mem_ready` in fixed duty-cycle patterns. The bench sweeps one to four beats against every pairing of three valid patterns and three ready patterns. It also sweeps all 256 enable masks.

// File: rtl/flash_dma_pkg.sv
package flash_dma_pkg;
  typedef enum logic [2:0] {
    SEL_SRC  = 3'd0,
    SEL_DST  = 3'd1,
    SEL_END  = 3'd2,
    SEL_CTRL = 3'd3,
    SEL_STAT = 3'd4,
    SEL_EN   = 3'd5
  } cfg_sel_e;

  localparam int IRQ_W    = 8;
  localparam int DONE_BIT = 7;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import flash_dma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int BEAT_BYTES = 16,
  parameter int MAX_BYTES  = 4194304
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic             done,
  output logic             go,
  output logic             busy,
  output logic             err,
  output logic [AW-1:0]    src_r,
  output logic [AW-1:0]    dst_r,
  output logic [AW-1:0]    end_r,
  output logic [IRQ_W-1:0] stat,
  output logic             irq
);
  localparam int OFS = $clog2(BEAT_BYTES);

  logic [IRQ_W-1:0] en_r;
  logic [AW:0]      span;
  logic             bad, start_req, rej;
  logic [IRQ_W-1:0] stat_nxt;

  assign span      = {1'b0, end_r} - {1'b0, dst_r};
  assign bad       = (|src_r[OFS-1:0]) || (|dst_r[OFS-1:0]) || (|end_r[OFS-1:0])
                     || (end_r <= dst_r) || (span > (AW+1)'(MAX_BYTES));
  assign start_req = cfg_we && (cfg_sel == SEL_CTRL) && cfg_wdata[0];
  assign go        = start_req && !busy && !bad;
  assign rej       = start_req && !busy && bad;
  assign irq       = |(stat & en_r);

  always_comb begin
    stat_nxt = stat;
    if (cfg_we && cfg_sel == SEL_STAT) stat_nxt = stat & ~cfg_wdata[IRQ_W-1:0];
    if (done) stat_nxt[DONE_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_r <= '0; dst_r <= '0; end_r <= '0;
      en_r  <= '0; stat  <= '0;
      busy  <= 1'b0; err <= 1'b0;
    end else begin
      if (cfg_we && cfg_sel == SEL_SRC) src_r <= cfg_wdata;
      if (cfg_we && cfg_sel == SEL_DST) dst_r <= cfg_wdata;
      if (cfg_we && cfg_sel == SEL_END) end_r <= cfg_wdata;
      if (cfg_we && cfg_sel == SEL_EN)  en_r  <= cfg_wdata[IRQ_W-1:0];
      stat <= stat_nxt;
      if (go)        busy <= 1'b1;
      else if (done) busy <= 1'b0;
      if (rej)       err <= 1'b1;
      else if (go)   err <= 1'b0;
    end
  end

  // R3
  reject_holds_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej |=> (err && !busy));
  // R7
  done_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> stat[DONE_BIT]);
  // R10
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req && !done) |=> busy);
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW         = 32,
  parameter int BEAT_BYTES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] src_r,
  input  logic [AW-1:0] dst_r,
  input  logic [AW-1:0] end_r,
  input  logic          fl_take,
  input  logic          beat_take,
  output logic [AW-1:0] src_lat,
  output logic [AW-1:0] ptr,
  output logic          last_beat,
  output logic          left_nz
);
  logic [AW:0]   left;
  logic [AW-1:0] end_lat;

  assign left_nz   = (left != '0);
  assign last_beat = (ptr + AW'(BEAT_BYTES)) == end_lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left <= '0; ptr <= '0; end_lat <= '0; src_lat <= '0;
    end else if (go) begin
      left    <= {1'b0, end_r} - {1'b0, dst_r};
      ptr     <= dst_r;
      end_lat <= end_r;
      src_lat <= src_r;
    end else begin
      if (fl_take)   left <= left - 1'b1;
      if (beat_take) ptr  <= ptr + AW'(BEAT_BYTES);
    end
  end

  // R11
  no_extra_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !left_nz |-> !fl_take);
endmodule

// File: rtl/dma_packer.sv
module dma_packer #(
  parameter int BEAT_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    fl_valid,
  input  logic [7:0]              fl_data,
  output logic                    fl_ready,
  output logic                    fl_take,
  input  logic                    mem_ready,
  output logic                    mem_valid,
  output logic [BEAT_BYTES*8-1:0] mem_data,
  output logic                    beat_take
);
  localparam int CW = $clog2(BEAT_BYTES);

  logic [CW-1:0]           cnt;
  logic [BEAT_BYTES*8-1:0] acc, acc_nxt;
  logic                    full, last_byte;

  assign last_byte = (cnt == CW'(BEAT_BYTES-1));
  assign fl_ready  = en && (!last_byte || !full || mem_ready);
  assign fl_take   = fl_valid && fl_ready;
  assign beat_take = full && mem_ready;
  assign mem_valid = full;

  always_comb begin
    acc_nxt = acc;
    acc_nxt[cnt*8 +: 8] = fl_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; acc <= '0; full <= 1'b0; mem_data <= '0;
    end else begin
      if (fl_take) begin
        acc <= acc_nxt;
        cnt <= last_byte ? '0 : cnt + 1'b1;
      end
      if (fl_take && last_byte) begin
        mem_data <= acc_nxt;
        full     <= 1'b1;
      end else if (beat_take) begin
        full <= 1'b0;
      end
    end
  end

  // R5
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_data)));
endmodule

// File: rtl/flash_rd_dma.sv
module flash_rd_dma
  import flash_dma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int BEAT_BYTES = 16,
  parameter int MAX_BYTES  = 4194304
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [2:0]              cfg_sel,
  input  logic [AW-1:0]           cfg_wdata,
  output logic                    dma_busy,
  output logic                    dma_err,
  output logic [IRQ_W-1:0]        irq_stat,
  output logic                    irq,
  output logic                    fl_req,
  output logic [AW-1:0]           fl_addr,
  input  logic                    fl_valid,
  output logic                    fl_ready,
  input  logic [7:0]              fl_data,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic [AW-1:0]           mem_addr,
  output logic [BEAT_BYTES*8-1:0] mem_data
);
  logic          go, done, fl_take, beat_take, last_beat, left_nz;
  logic [AW-1:0] src_r, dst_r, end_r;

  assign done   = beat_take && last_beat;
  assign fl_req = dma_busy && left_nz;

  dma_regs #(.AW(AW), .BEAT_BYTES(BEAT_BYTES), .MAX_BYTES(MAX_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .done(done), .go(go), .busy(dma_busy),
    .err(dma_err), .src_r(src_r), .dst_r(dst_r), .end_r(end_r),
    .stat(irq_stat), .irq(irq));

  dma_addr_gen #(.AW(AW), .BEAT_BYTES(BEAT_BYTES)) u_addr (
    .clk(clk), .rst_n(rst_n), .go(go), .src_r(src_r), .dst_r(dst_r),
    .end_r(end_r), .fl_take(fl_take), .beat_take(beat_take),
    .src_lat(fl_addr), .ptr(mem_addr), .last_beat(last_beat),
    .left_nz(left_nz));

  dma_packer #(.BEAT_BYTES(BEAT_BYTES)) u_pack (
    .clk(clk), .rst_n(rst_n), .en(fl_req), .fl_valid(fl_valid),
    .fl_data(fl_data), .fl_ready(fl_ready), .fl_take(fl_take),
    .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_data(mem_data),
    .beat_take(beat_take));

  // R2
  write_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> dma_busy);
  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> $stable(mem_addr));
endmodule

// File: tb/test_flash_rd_dma.sv
module test_flash_rd_dma;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic dma_busy, dma_err, irq, fl_req, fl_ready, mem_valid;
  logic [7:0] irq_stat;
  logic [31:0] fl_addr, mem_addr;
  logic fl_valid = 1'b0, mem_ready = 1'b0;
  logic [7:0] fl_data = '0;
  logic [127:0] mem_data;

  int total = 0, bad = 0;
  int vmode = 0, rmode = 0, cyc = 0;
  int byte_idx = 0, beat_idx = 0;
  logic [31:0] cur_src = 0, cur_dst = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_rd_dma i_flash_rd_dma (.*);

  function automatic logic [7:0] fbyte(input logic [31:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Source model and memory sink
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      case (vmode)
        0: fl_valid = 1'b1;
        1: fl_valid = (cyc % 3) != 0;
        default: fl_valid = (cyc % 4) == 0;
      endcase
      case (rmode)
        0: mem_ready = 1'b1;
        1: mem_ready = (cyc % 2) == 0;
        default: mem_ready = (cyc % 5) == 4;
      endcase
      fl_data = fbyte(cur_src + byte_idx);
      #1;
      if (mem_valid && mem_ready) begin
        logic [127:0] exp_d;
        for (int k = 0; k < 16; k++) exp_d[k*8 +: 8] = fbyte(cur_src + beat_idx*16 + k);
        // R4 R6: lane order and content
        chk(mem_data == exp_d, "R4/R6 beat data", mem_data[63:0], exp_d[63:0]);
        // R5: address order
        chk(mem_addr == cur_dst + beat_idx*16, "R5 beat address", mem_addr, cur_dst + beat_idx*16);
        beat_idx++;
      end
      if (fl_valid && fl_ready) byte_idx++;
    end
  end

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 5000 && dma_busy; n++) @(negedge clk);
  endtask

  task automatic run_xfer(input logic [31:0] s, input logic [31:0] d, input int len);
    cur_src = s; cur_dst = d; byte_idx = 0; beat_idx = 0;
    wr(3'd0, s); wr(3'd1, d); wr(3'd2, d + len);
    wr(3'd3, 32'h1);
    // R2
    chk(dma_busy && fl_req && fl_addr == s, "R2 start", {dma_busy, fl_req}, 2'b11);
    wait_idle();
    chk(!dma_busy, "R2 self clear", dma_busy, 0);
    chk(beat_idx == len/16, "R6 beat count", beat_idx, len/16);
    chk(byte_idx == len, "R11 byte count", byte_idx, len);
    chk(irq_stat[7] && !dma_err, "R7 done status", irq_stat, 8'h80);
    repeat (3) @(negedge clk);
    chk(byte_idx == len && !fl_ready, "R11 no further bytes", byte_idx, len);
  endtask

  task automatic try_bad(input logic [31:0] s, input logic [31:0] d, input logic [31:0] e);
    byte_idx = 0; beat_idx = 0;
    wr(3'd0, s); wr(3'd1, d); wr(3'd2, e);
    wr(3'd3, 32'h1);
    repeat (4) @(negedge clk);
    // R3
    chk(dma_err && !dma_busy && byte_idx == 0 && beat_idx == 0, "R3 reject",
        {dma_err, dma_busy}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!dma_busy && !dma_err && !irq && !fl_req && !mem_valid && irq_stat == 0,
        "R1 reset", {dma_busy, dma_err, irq, fl_req, mem_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int len = 16; len <= 64; len += 16)
      for (int v = 0; v < 3; v++)
        for (int r = 0; r < 3; r++) begin
          vmode = v; rmode = r;
          run_xfer(32'h0010_0000 + len*256 + v*32, 32'h8000_0000 + r*4096, len);
          wr(3'd4, 32'h80);
          chk(irq_stat == 0, "R8 clear", irq_stat, 0);
        end

    // R9: enable mask sweep with status bit 7 set
    vmode = 0; rmode = 0;
    run_xfer(32'h40, 32'h200, 32);
    for (int e = 0; e < 256; e++) begin
      wr(3'd5, e);
      chk(irq == e[7], "R9 irq mask", irq, e[7]);
    end
    // R8: zeros leave bits, ones clear
    wr(3'd4, 32'h7F);
    chk(irq_stat == 8'h80 && irq, "R8 write zero keeps", irq_stat, 8'h80);
    wr(3'd4, 32'h80);
    chk(irq_stat == 8'h00 && !irq, "R8 write one clears", irq_stat, 0);

    // R3: each rejection cause
    try_bad(32'h104, 32'h1000, 32'h1040);
    try_bad(32'h100, 32'h1008, 32'h1040);
    try_bad(32'h100, 32'h1000, 32'h1041);
    try_bad(32'h100, 32'h1000, 32'h1000);
    try_bad(32'h100, 32'h1000, 32'h0FF0);
    try_bad(32'h100, 32'h0, 32'h0040_0010);
    run_xfer(32'h300, 32'h3000, 16);
    chk(!dma_err, "R3 error cleared by good start", dma_err, 0);
    wr(3'd4, 32'hFF);

    // R10: restart while busy
    vmode = 0; rmode = 2;
    cur_src = 32'h500; cur_dst = 32'h5000; byte_idx = 0; beat_idx = 0;
    wr(3'd0, 32'h500); wr(3'd1, 32'h5000); wr(3'd2, 32'h5040);
    wr(3'd3, 32'h1);
    repeat (6) @(negedge clk);
    wr(3'd0, 32'h900); wr(3'd2, 32'h5080);
    wr(3'd3, 32'h1);
    chk(dma_busy && fl_addr == 32'h500, "R10 restart ignored", fl_addr, 32'h500);
    wait_idle();
    chk(beat_idx == 4 && byte_idx == 64, "R10 original length", beat_idx, 4);
    repeat (20) @(negedge clk);
    chk(!dma_busy && beat_idx == 4, "R10 single completion", beat_idx, 4);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule